// File: doc/BRIEF.md
# Supply and Fault Protection Sequencer

This block is the mode manager of a switching power controller. It takes comparator decisions that have already been turned into clocked digital flags (supply thresholds, mains-level check, an external disable, an external latch request, an over-temperature flag and an overload flag from the peak-setpoint logic). From them it drives three outputs: the enable of the high-voltage startup current source, the enable that lets gate pulses out, and a one-cycle restart strobe that starts the soft-start ramp.

On power-up the current source charges the supply until it reaches the start level. Switching then begins with a soft-started restart. While running, the current source regulates the supply between the stop and start levels. A sustained overload, or a supply sag to the undervoltage level while the source is on, sends the block into a burst recovery. In that recovery the source only recharges from the low latch level, and the output is released on the second recharge. A latch request parks the block in the same low-level recharge loop. Only a supply collapse below the reset level releases it. Transient conditions (overvoltage, mains too low, disable, thermal shutdown) only gate pulses for as long as they last.

Top module: `supply_prot_seq`

## Requirements
- R1: While reset is held and right after it, the block is in the startup charge: `hv_src_en`=1, `pulse_en`=0, `ss_restart`=0.
- R2: In startup, `vcc_above_start`=1 moves the block to run. `pulse_en` goes to 1 one clock after the edge that samples it.
- R3: `ss_restart` is high for exactly one cycle, the first cycle in which `pulse_en` is 1 after any cycle with `pulse_en` at 0.
- R4: In run or stop-hold, the source switches on one clock after `vcc_below_stop`=1 and off one clock after `vcc_above_start`=1, and pulses continue.
- R5: `vcc_below_uv`=1 enters protection (pulses off next clock) only if `hv_src_en` is 1 in that cycle. When the source is off, it has no effect.
- R6: While running, `overload`=1 on FAULT_TC consecutive edges leaves pulses on. The next edge with `overload` still 1 enters protection. Any cycle with `overload`=0 restarts the count.
- R7: In protection the source stays off until `vcc_below_latch`=1, then stays on until `vcc_above_start`=1. The output stays off through the first such recharge. It restarts with `ss_restart` at the end of the second.
- R8: Any of `vcc_above_ovp`=1, `bo_ok`=0, `disable_req`=1 or `therm_sd`=1 turns pulses off on the next clock. Once all clear, pulses return on the next clock with a restart strobe.
- R9: `perm_latch_req`=1 stops pulses and runs the same low-level recharge loop, with the output never released, even after the request drops. Only `vcc_below_reset`=1 returns the block to startup.
- R10: Priority when several apply at once: reset-level collapse, then latch request, then protection, then stop conditions, then run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| vcc_above_start | input | 1 | Supply at or above start level |
| vcc_below_stop | input | 1 | Supply below regulation stop level |
| vcc_below_uv | input | 1 | Supply below undervoltage level |
| vcc_below_latch | input | 1 | Supply below latch recharge level |
| vcc_below_reset | input | 1 | Supply below latch release level |
| vcc_above_ovp | input | 1 | Supply above overvoltage level |
| bo_ok | input | 1 | Mains level acceptable |
| disable_req | input | 1 | External output disable |
| perm_latch_req | input | 1 | External permanent latch request |
| therm_sd | input | 1 | Thermal shutdown |
| overload | input | 1 | Overload flag from setpoint logic |
| hv_src_en | output | 1 | Startup current source enable |
| pulse_en | output | 1 | Gate pulse enable |
| ss_restart | output | 1 | One-cycle soft-start trigger |

## Verification
The bench drives the fault count to exactly FAULT_TC edges and one beyond. An off-by-one timer would trip early or late there, and a timer that never clears would trip across a one-cycle gap. It walks both recharge loops of protection. A design that released output on the first recharge, or counted a charge that never dipped to the low level, shows pulses too soon. It applies undervoltage with the source off and on, where a missing qualification would trip spuriously. It also stacks every condition at once, where a wrong priority leaves the output running or the latch releasable.

// File: rtl/supply_prot_pkg.sv
package supply_prot_pkg;

  typedef enum logic [3:0] {
    ST_START  = 4'd0,
    ST_RUN    = 4'd1,
    ST_HOLD   = 4'd2,
    ST_PWAIT1 = 4'd3,
    ST_PCHG1  = 4'd4,
    ST_PWAIT2 = 4'd5,
    ST_PCHG2  = 4'd6,
    ST_LWAIT  = 4'd7,
    ST_LCHG   = 4'd8
  } seq_state_e;

  function automatic logic stop_cond(input logic ovp, input logic bo_good,
                                     input logic dis, input logic tsd);
    return ovp | ~bo_good | dis | tsd;
  endfunction

  function automatic logic in_supply_loop(input seq_state_e s);
    return (s == ST_RUN) || (s == ST_HOLD);
  endfunction

  function automatic logic in_latch(input seq_state_e s);
    return (s == ST_LWAIT) || (s == ST_LCHG);
  endfunction

  function automatic logic in_prot(input seq_state_e s);
    return (s == ST_PWAIT1) || (s == ST_PCHG1) || (s == ST_PWAIT2) || (s == ST_PCHG2);
  endfunction

endpackage

// File: rtl/supply_prot_fault_timer.sv
module supply_prot_fault_timer #(
  parameter int unsigned FAULT_TC = 10_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic count_en,
  input  logic flag,
  output logic trip
);
  localparam int unsigned CW = $clog2(FAULT_TC + 1);
  localparam logic [CW-1:0] TC = CW'(FAULT_TC);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt_q <= '0;
    else if (!(count_en && flag)) cnt_q <= '0;
    else if (cnt_q != TC)       cnt_q <= cnt_q + 1'b1;
  end

  assign trip = count_en && flag && (cnt_q == TC);
endmodule

// File: rtl/supply_prot_dss.sv
module supply_prot_dss (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic below_stop,
  input  logic above_start,
  output logic src_on
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           src_on <= 1'b0;
    else if (!active)     src_on <= 1'b0;
    else if (above_start) src_on <= 1'b0;
    else if (below_stop)  src_on <= 1'b1;
  end
endmodule

// File: rtl/supply_prot_fsm.sv
module supply_prot_fsm
  import supply_prot_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       above_start,
  input  logic       below_latch,
  input  logic       below_reset,
  input  logic       below_uv,
  input  logic       stop,
  input  logic       latch_req,
  input  logic       fault_trip,
  input  logic       dss_on,
  output seq_state_e state,
  output logic       restart_q,
  output logic       prot_entry
);
  seq_state_e nxt;
  seq_state_e resume;

  assign resume     = stop ? ST_HOLD : ST_RUN;
  assign prot_entry = in_supply_loop(state) && (fault_trip || (below_uv && dss_on));

  always_comb begin
    nxt = state;
    if (below_reset) begin
      nxt = ST_START;
    end else if (latch_req || in_latch(state)) begin
      unique case (state)
        ST_LWAIT: if (below_latch) nxt = ST_LCHG;
        ST_LCHG:  if (above_start) nxt = ST_LWAIT;
        default:  nxt = ST_LWAIT;
      endcase
    end else if (prot_entry || in_prot(state)) begin
      unique case (state)
        ST_PWAIT1: if (below_latch) nxt = ST_PCHG1;
        ST_PCHG1:  if (above_start) nxt = ST_PWAIT2;
        ST_PWAIT2: if (below_latch) nxt = ST_PCHG2;
        ST_PCHG2:  if (above_start) nxt = resume;
        default:   nxt = ST_PWAIT1;
      endcase
    end else begin
      unique case (state)
        ST_START: if (above_start) nxt = resume;
        ST_RUN:   if (stop) nxt = ST_HOLD;
        ST_HOLD:  if (!stop) nxt = ST_RUN;
        default:  nxt = ST_START;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_START;
      restart_q <= 1'b0;
    end else begin
      state     <= nxt;
      restart_q <= (nxt == ST_RUN) && (state != ST_RUN);
    end
  end
endmodule

// File: rtl/supply_prot_seq.sv
module supply_prot_seq
  import supply_prot_pkg::*;
#(
  parameter int unsigned FAULT_TC = 10_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic vcc_above_start,
  input  logic vcc_below_stop,
  input  logic vcc_below_uv,
  input  logic vcc_below_latch,
  input  logic vcc_below_reset,
  input  logic vcc_above_ovp,
  input  logic bo_ok,
  input  logic disable_req,
  input  logic perm_latch_req,
  input  logic therm_sd,
  input  logic overload,
  output logic hv_src_en,
  output logic pulse_en,
  output logic ss_restart
);
  seq_state_e state;
  logic       stop_now;
  logic       fault_trip;
  logic       dss_on;
  logic       prot_entry;
  logic       latched;

  assign stop_now = stop_cond(vcc_above_ovp, bo_ok, disable_req, therm_sd);
  assign latched  = in_latch(state);

  supply_prot_fault_timer #(.FAULT_TC(FAULT_TC)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .count_en (state == ST_RUN),
    .flag     (overload),
    .trip     (fault_trip)
  );

  supply_prot_dss u_dss (
    .clk         (clk),
    .rst_n       (rst_n),
    .active      (in_supply_loop(state)),
    .below_stop  (vcc_below_stop),
    .above_start (vcc_above_start),
    .src_on      (dss_on)
  );

  supply_prot_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .above_start (vcc_above_start),
    .below_latch (vcc_below_latch),
    .below_reset (vcc_below_reset),
    .below_uv    (vcc_below_uv),
    .stop        (stop_now),
    .latch_req   (perm_latch_req),
    .fault_trip  (fault_trip),
    .dss_on      (dss_on),
    .state       (state),
    .restart_q   (ss_restart),
    .prot_entry  (prot_entry)
  );

  always_comb begin
    unique case (state)
      ST_START, ST_PCHG1, ST_PCHG2, ST_LCHG: hv_src_en = 1'b1;
      ST_RUN, ST_HOLD:                       hv_src_en = dss_on;
      default:                               hv_src_en = 1'b0;
    endcase
  end

  assign pulse_en = (state == ST_RUN);
endmodule

// File: rtl/supply_prot_seq_chk.sv
module supply_prot_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic vcc_above_ovp,
  input logic bo_ok,
  input logic disable_req,
  input logic therm_sd,
  input logic perm_latch_req,
  input logic vcc_below_reset,
  input logic vcc_below_stop,
  input logic vcc_below_latch,
  input logic overload,
  input logic fault_trip,
  input logic latched,
  input logic hv_src_en,
  input logic pulse_en,
  input logic ss_restart
);
  AST_STOP_GATES: assert property (@(posedge clk) disable iff (!rst_n)
    (vcc_above_ovp || !bo_ok || disable_req || therm_sd || perm_latch_req || vcc_below_reset)
    |=> !pulse_en); // R8

  AST_RESTART_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    ss_restart |=> !ss_restart); // R3

  AST_RESTART_WITH_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    ss_restart |-> pulse_en); // R3

  AST_LATCH_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (latched && !vcc_below_reset) |=> latched); // R9

  AST_LATCH_NO_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    latched |-> !pulse_en); // R9

  AST_SRC_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hv_src_en) |-> $past(vcc_below_stop || vcc_below_latch || vcc_below_reset)); // R4

  AST_TRIP_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    fault_trip |-> (overload && $past(overload))); // R6
endmodule

bind supply_prot_seq supply_prot_seq_chk u_seq_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .vcc_above_ovp   (vcc_above_ovp),
  .bo_ok           (bo_ok),
  .disable_req     (disable_req),
  .therm_sd        (therm_sd),
  .perm_latch_req  (perm_latch_req),
  .vcc_below_reset (vcc_below_reset),
  .vcc_below_stop  (vcc_below_stop),
  .vcc_below_latch (vcc_below_latch),
  .overload        (overload),
  .fault_trip      (fault_trip),
  .latched         (latched),
  .hv_src_en       (hv_src_en),
  .pulse_en        (pulse_en),
  .ss_restart      (ss_restart)
);

// File: tb/test_supply_prot_seq.sv
`timescale 1ns/1ps
module test_supply_prot_seq;
  localparam int unsigned TC = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic vcc_above_start, vcc_below_stop, vcc_below_uv, vcc_below_latch;
  logic vcc_below_reset, vcc_above_ovp, bo_ok, disable_req, perm_latch_req;
  logic therm_sd, overload;
  logic hv_src_en, pulse_en, ss_restart;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  supply_prot_seq #(.FAULT_TC(TC)) i_supply_prot_seq (
    .clk(clk), .rst_n(rst_n),
    .vcc_above_start(vcc_above_start), .vcc_below_stop(vcc_below_stop),
    .vcc_below_uv(vcc_below_uv), .vcc_below_latch(vcc_below_latch),
    .vcc_below_reset(vcc_below_reset), .vcc_above_ovp(vcc_above_ovp),
    .bo_ok(bo_ok), .disable_req(disable_req), .perm_latch_req(perm_latch_req),
    .therm_sd(therm_sd), .overload(overload),
    .hv_src_en(hv_src_en), .pulse_en(pulse_en), .ss_restart(ss_restart)
  );

  task automatic tick(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic expect3(string req, logic src, logic pul, logic rs);
    checks++;
    if (hv_src_en !== src || pulse_en !== pul || ss_restart !== rs) begin
      errors++;
      $display("FAIL %s: src/pulse/restart got %b%b%b expected %b%b%b",
               req, hv_src_en, pulse_en, ss_restart, src, pul, rs);
    end
  endtask

  task automatic quiet();
    vcc_above_start = 0; vcc_below_stop = 0; vcc_below_uv = 0;
    vcc_below_latch = 0; vcc_below_reset = 0; vcc_above_ovp = 0;
    bo_ok = 1; disable_req = 0; perm_latch_req = 0; therm_sd = 0; overload = 0;
  endtask

  // reach run state from anywhere via reset-level collapse
  task automatic go_run();
    quiet(); vcc_below_reset = 1; tick();
    vcc_below_reset = 0; vcc_above_start = 1; tick();
    vcc_above_start = 0; tick();
  endtask

  task automatic t_reset();
    quiet();
    rst_n = 0; tick(2);
    expect3("R1 in reset", 1, 0, 0);
    rst_n = 1; tick(3);
    expect3("R1 after reset", 1, 0, 0);
  endtask

  task automatic t_startup();
    vcc_above_start = 1; tick();
    expect3("R2/R3 start", 0, 1, 1);
    vcc_above_start = 0; tick();
    expect3("R3 strobe one cycle", 0, 1, 0);
  endtask

  task automatic t_dss();
    go_run();
    vcc_below_stop = 1; tick();
    expect3("R4 source on at stop", 1, 1, 0);
    vcc_below_stop = 0; tick(2);
    expect3("R4 source holds", 1, 1, 0);
    vcc_above_start = 1; tick();
    expect3("R4 source off at start", 0, 1, 0);
    vcc_above_start = 0;
  endtask

  task automatic t_uv();
    go_run();
    vcc_below_uv = 1; tick(2);
    expect3("R5 uv ignored with source off", 0, 1, 0);
    vcc_below_uv = 0; vcc_below_stop = 1; tick();
    vcc_below_stop = 0; vcc_below_uv = 1; tick();
    expect3("R5 uv with source on", 0, 0, 0);
    vcc_below_uv = 0;
  endtask

  task automatic t_fault();
    go_run();
    overload = 1; tick(TC - 2);
    overload = 0; tick();
    overload = 1; tick(TC);
    expect3("R6 count restarted after gap", 0, 1, 0);
    tick();
    expect3("R6 trip one past terminal count", 0, 0, 0);
    overload = 0;
  endtask

  task automatic t_protection();
    // continues from a protection entry
    vcc_above_start = 1; tick(2);
    expect3("R7 no recharge above latch level", 0, 0, 0);
    vcc_above_start = 0; vcc_below_latch = 1; tick();
    expect3("R7 first recharge", 1, 0, 0);
    vcc_below_latch = 0; vcc_above_start = 1; tick();
    expect3("R7 output held after first charge", 0, 0, 0);
    vcc_above_start = 0; vcc_below_latch = 1; tick();
    expect3("R7 second recharge", 1, 0, 0);
    vcc_below_latch = 0; vcc_above_start = 1; tick();
    expect3("R7/R3 restart on second charge", 0, 1, 1);
    vcc_above_start = 0;
  endtask

  task automatic t_stop();
    go_run();
    vcc_above_ovp = 1; tick();
    expect3("R8 ovp stops", 0, 0, 0);
    vcc_above_ovp = 0; bo_ok = 0; tick();
    expect3("R8 brown-out stops", 0, 0, 0);
    vcc_below_stop = 1; tick();
    expect3("R8/R4 self-supply while held", 1, 0, 0);
    vcc_below_stop = 0; bo_ok = 1; disable_req = 1; therm_sd = 1; tick();
    expect3("R8 disable and thermal", 1, 0, 0);
    disable_req = 0; tick();
    expect3("R8 thermal alone", 1, 0, 0);
    therm_sd = 0; tick();
    expect3("R8/R3 resume with restart", 1, 1, 1);
  endtask

  task automatic t_latch();
    go_run();
    perm_latch_req = 1; tick();
    expect3("R9 latch stops", 0, 0, 0);
    perm_latch_req = 0; vcc_above_start = 1; tick(2);
    expect3("R9 latch ignores start", 0, 0, 0);
    vcc_above_start = 0; vcc_below_latch = 1; tick();
    expect3("R9 recharge at low level", 1, 0, 0);
    vcc_below_latch = 0; vcc_above_start = 1; tick();
    vcc_above_start = 0; vcc_below_latch = 1; tick();
    vcc_below_latch = 0; vcc_above_start = 1; tick();
    expect3("R9 never released by recharges", 0, 0, 0);
    vcc_above_start = 0; vcc_below_reset = 1; tick();
    expect3("R9 reset level releases", 1, 0, 0);
    vcc_below_reset = 0; vcc_above_start = 1; tick();
    expect3("R9 restart after release", 0, 1, 1);
    vcc_above_start = 0;
  endtask

  task automatic t_priority();
    go_run();
    vcc_below_stop = 1; tick();
    vcc_below_stop = 0;
    vcc_below_reset = 1; perm_latch_req = 1; vcc_below_uv = 1; overload = 1; therm_sd = 1;
    tick();
    expect3("R10 reset wins", 1, 0, 0);
    vcc_below_reset = 0; vcc_below_uv = 0; overload = 0; therm_sd = 0;
    vcc_above_start = 1; tick();
    expect3("R10 latch beats startup", 0, 0, 0);
    go_run();
    vcc_below_stop = 1; tick();
    vcc_below_stop = 0; vcc_below_uv = 1; vcc_above_ovp = 1; tick();
    vcc_below_uv = 0; vcc_above_ovp = 0; vcc_above_start = 1; tick();
    expect3("R10 protection beats stop", 0, 0, 0);
    vcc_above_start = 0;
  endtask

  initial begin
    t_reset();
    t_startup();
    t_dss();
    t_uv();
    t_protection();
    t_fault();
    t_protection();
    t_stop();
    t_latch();
    t_priority();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(8 * 100_000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule